// File: doc/BRIEF.md
# DRAM Burst Column Order Generator

This block turns one read or write command into an eight-beat sequence of column offsets. Each offset names the word within an aligned group of eight that moves on that beat. The command carries a 3-bit start column, a read/write flag, a burst-type select (sequential or interleaved), a 2-bit length mode and an active-low chop pin. From these the block decides whether the burst is a full eight beats or is chopped to four. It then produces one beat per clock cycle for eight cycles. For each beat it gives the column, a flag saying whether the beat carries real data, an output-drive enable for reads, and a flag saying whether the internal write start moves two clocks earlier.

The beat stream has no back-pressure. Once a command is accepted, the eight beats follow on consecutive cycles and cannot be stalled. A command offered while `busy` is high is dropped, so the source must hold a command until it sees `busy` low. Latency timing, data paths and mode-register writes belong to neighbouring logic.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous reset, and whenever no burst is running, `busy`, `beat_valid`, `beat_drive` and `wr_early` are low and `beat_col` is 0.
- R2: A command with `cmd_valid` high while `busy` is low is taken at that clock edge. `busy` is then high for exactly 8 cycles starting in the next cycle, with beats 0 to 7 presented one per cycle in that order.
- R3: A command offered while `busy` is high has no effect. The running burst continues unchanged and no extra burst follows it.
- R4: Sequential read (`cmd_interleave`=0): beat i outputs column bit 2 = start[2] XOR i[2], and bits 1:0 = (start[1:0] + i[1:0]) mod 4.
- R5: Interleaved read (`cmd_interleave`=1): beat i outputs column start XOR i.
- R6: Chopped read: beats 0 to 3 follow R4 or R5 with `beat_valid` and `beat_drive` high. On beats 4 to 7 both are low, so the data and strobe drivers are released.
- R7: Chopped write: beats 0 to 3 output columns {start[2], i[1:0]}, ignoring start bits 1:0 and the burst type. Beats 4 to 7 have `beat_valid` low. `beat_drive` is low on every write beat.
- R8: Full 8-beat write: beat i outputs column i, whatever the start column and burst type.
- R9: Length mode decode: 2'b00 and 2'b11 give 8 beats, 2'b10 gives a chop to 4, and 2'b01 takes the chop from `cmd_chop_n` at the command (low = chop to 4, high = 8).
- R10: `wr_early` is high on every beat of a write burst that was chopped by mode 2'b10. It is low for writes chopped on the fly with mode 2'b01, for full writes and for all reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_is_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W | Start column within the aligned group |
| cmd_interleave | input | 1 | 0 = sequential, 1 = interleaved |
| cmd_len_mode | input | 2 | Burst length mode |
| cmd_chop_n | input | 1 | Per-command chop select, low = chop to 4 |
| busy | output | 1 | Burst in progress |
| beat_col | output | COL_W | Column offset of the current beat |
| beat_valid | output | 1 | Current beat carries data |
| beat_drive | output | 1 | Output-drive enable for read beats |
| wr_early | output | 1 | Internal write start pulled in by two clocks |

## Verification
The assertions assume that reset is held high from time zero until after the first clock edge, and that the inputs are known levels at each edge where `busy` is low. They assume nothing about what the inputs do while a burst runs. The stimulus changes inputs only on falling edges, starts every command from idle, and deliberately offers junk commands in the middle of a burst to show they are ignored. Because the stream has no back-pressure, the bench takes one expected item from its queue on every busy cycle. Column values are compared only on beats flagged valid.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [1:0] {
    LEN_FULL   = 2'b00,
    LEN_PERCMD = 2'b01,
    LEN_HALF   = 2'b10,
    LEN_SPARE  = 2'b11
  } len_mode_e;

  typedef struct packed {
    logic is_wr;
    logic il;
    logic chop;
    logic early;
  } burst_attr_t;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import burst_col_pkg::*;
(
  input  logic [1:0]  len_mode,
  input  logic        chop_n,
  input  logic        is_wr,
  input  logic        il,
  output burst_attr_t attr
);

  len_mode_e mode;

  always_comb begin
    mode       = len_mode_e'(len_mode);
    attr.is_wr = is_wr;
    attr.il    = il;
    unique case (mode)
      LEN_HALF:   attr.chop = 1'b1;
      LEN_PERCMD: attr.chop = ~chop_n;
      default:    attr.chop = 1'b0;
    endcase
    // a fixed half burst moves the internal write start earlier
    attr.early = is_wr & (mode == LEN_HALF);
  end

endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [COL_W-1:0] idx
);

  logic last;

  assign last = &idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/bcs_col_order.sv
module bcs_col_order
  import burst_col_pkg::*;
#(
  parameter int COL_W = 3
) (
  input  burst_attr_t      attr,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col
);

  localparam int MSB = COL_W - 1;

  logic [COL_W-1:0] rd_seq;
  logic [COL_W-1:0] rd_il;
  logic [COL_W-1:0] wr_half;

  // interleaved: every bit toggles with the matching beat bit
  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_il
      assign rd_il[b] = start_col[b] ^ idx[b];
    end
  endgenerate

  // sequential: wrap inside the half holding the start, then swap halves
  assign rd_seq[MSB]     = start_col[MSB] ^ idx[MSB];
  assign rd_seq[MSB-1:0] = start_col[MSB-1:0] + idx[MSB-1:0];

  // chopped write keeps only the half-select bit of the start
  assign wr_half = {start_col[MSB], idx[MSB-1:0]};

  always_comb begin
    if (!attr.is_wr)
      col = attr.il ? rd_il : rd_seq;
    else if (attr.chop)
      col = wr_half;
    else
      col = idx;
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_is_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_interleave,
  input  logic [1:0]       cmd_len_mode,
  input  logic             cmd_chop_n,
  output logic             busy,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_valid,
  output logic             beat_drive,
  output logic             wr_early
);

  localparam int MSB = COL_W - 1;

  burst_attr_t      new_attr;
  burst_attr_t      attr_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] order_col;
  logic             start;
  logic             in_tail;

  assign start = cmd_valid & ~busy;

  bcs_len_decode u_dec (
    .len_mode (cmd_len_mode),
    .chop_n   (cmd_chop_n),
    .is_wr    (cmd_is_write),
    .il       (cmd_interleave),
    .attr     (new_attr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q <= '0;
      col_q  <= '0;
    end else if (start) begin
      attr_q <= new_attr;
      col_q  <= cmd_col;
    end
  end

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .idx   (idx)
  );

  bcs_col_order #(.COL_W(COL_W)) u_ord (
    .attr      (attr_q),
    .start_col (col_q),
    .idx       (idx),
    .col       (order_col)
  );

  assign in_tail    = attr_q.chop & idx[MSB];
  assign beat_col   = busy ? order_col : '0;
  assign beat_valid = busy & ~in_tail;
  assign beat_drive = busy & ~in_tail & ~attr_q.is_wr;
  assign wr_early   = busy & attr_q.early;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 3
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic busy,
  input logic beat_valid,
  input logic beat_drive,
  input logic wr_early
);

  localparam int BEATS = 1 << COL_W;

  logic [COL_W:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < (COL_W+1)'(BEATS)));

  // R2
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(run_q) == (COL_W+1)'(BEATS - 1)));

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> beat_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!beat_valid && !beat_drive && !wr_early));

  // R6
  drive_valid_chk: assert property (@(posedge clk) disable iff (rst)
    beat_drive |-> beat_valid);

  // R10
  early_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    wr_early |-> !beat_drive);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .busy       (busy),
  .beat_valid (beat_valid),
  .beat_drive (beat_drive),
  .wr_early   (wr_early)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_write = 1'b0;
  logic [2:0] cmd_col = '0;
  logic       cmd_interleave = 1'b0;
  logic [1:0] cmd_len_mode = 2'b00;
  logic       cmd_chop_n = 1'b1;
  logic       busy;
  logic [2:0] beat_col;
  logic       beat_valid;
  logic       beat_drive;
  logic       wr_early;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       v;
    logic       d;
    logic       e;
    logic [2:0] c;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(3)) u0 (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .cmd_is_write   (cmd_is_write),
    .cmd_col        (cmd_col),
    .cmd_interleave (cmd_interleave),
    .cmd_len_mode   (cmd_len_mode),
    .cmd_chop_n     (cmd_chop_n),
    .busy           (busy),
    .beat_col       (beat_col),
    .beat_valid     (beat_valid),
    .beat_drive     (beat_drive),
    .wr_early       (wr_early)
  );

  // monitor: one expected item per busy cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R3: unexpected beat col=%0d valid=%0b, expected idle", beat_col, beat_valid);
        end else begin
          exp_t x;
          x = sb.pop_front();
          if (beat_valid !== x.v || beat_drive !== x.d || wr_early !== x.e ||
              (x.v && beat_col !== x.c)) begin
            errors++;
            $display("FAIL %s: col=%0d v=%0b d=%0b e=%0b, expected col=%0d v=%0b d=%0b e=%0b",
                     x.tag, beat_col, beat_valid, beat_drive, wr_early, x.c, x.v, x.d, x.e);
          end
        end
      end else begin
        checks++;
        if (beat_valid !== 1'b0 || beat_drive !== 1'b0 || wr_early !== 1'b0 || beat_col !== 3'd0) begin
          errors++;
          $display("FAIL R1: idle col=%0d v=%0b d=%0b e=%0b, expected 0 0 0 0",
                   beat_col, beat_valid, beat_drive, wr_early);
        end
      end
    end
  end

  task automatic issue(input bit w, input int c, input bit il, input bit cn,
                       input logic [1:0] m, input bit intrude, input string tag);
    bit chop;
    bit early;
    chop  = (m == 2'b10) || (m == 2'b01 && !cn);
    early = w && (m == 2'b10);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      exp_t x;
      int col;
      if (!w)      col = il ? (c ^ i) : (((c ^ i) & 4) | ((c + i) & 3));
      else if (chop) col = (c & 4) | (i & 3);
      else         col = i;
      x.v   = !(chop && i >= 4);
      x.d   = x.v && !w;
      x.e   = early;
      x.c   = 3'(col);
      x.tag = tag;
      sb.push_back(x);
    end
    cmd_valid      = 1'b1;
    cmd_is_write   = w;
    cmd_col        = 3'(c);
    cmd_interleave = il;
    cmd_len_mode   = m;
    cmd_chop_n     = cn;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (intrude && k == 2) begin
        // R3: junk command mid-burst
        cmd_valid      = 1'b1;
        cmd_is_write   = ~w;
        cmd_col        = 3'(c + 3);
        cmd_interleave = ~il;
        cmd_len_mode   = 2'b10;
        cmd_chop_n     = 1'b0;
      end
      if (k == 3) cmd_valid = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R1: busy=%0b after reset, expected 0", busy);
    end
    for (int c = 0; c < 8; c++) begin
      issue(0, c, 0, 1, 2'b00, 0, "R4");
      issue(0, c, 1, 1, 2'b00, 0, "R5");
      issue(0, c, c[0], 1, 2'b10, 0, "R6");
      issue(1, c, c[1], 1, 2'b00, 0, "R8");
      issue(1, c, c[0], 1, 2'b10, 0, "R7");
    end
    issue(0, 5, 0, 0, 2'b01, 0, "R9");
    issue(0, 5, 1, 1, 2'b01, 0, "R9");
    issue(0, 6, 0, 0, 2'b11, 0, "R9");
    issue(1, 2, 1, 0, 2'b11, 0, "R9");
    issue(1, 7, 1, 0, 2'b01, 0, "R10");
    issue(1, 3, 0, 1, 2'b10, 0, "R10");
    issue(1, 1, 0, 1, 2'b01, 0, "R10");
    issue(0, 3, 1, 1, 2'b00, 1, "R3");
    issue(1, 6, 0, 1, 2'b00, 1, "R3");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R2: %0d beats missing busy=%0b, expected 0 and 0", sb.size(), busy);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule